// File: doc/BRIEF.md
# Gain-to-Duty Mode Scheduler

This block turns a requested voltage gain for a four-switch buck-boost power stage into a switching mode and two duty words. One duty word is for the buck leg and one is for the boost leg. It uses the ideal transfer relation gain = buck duty / (1 − boost duty). It splits the gain range into four regions: plain buck, two bridge sub-regions, and plain boost. Across all four regions the transfer stays continuous, and no leg is asked for a pulse shorter than the minimum the switches can make.

A request enters on a valid/ready handshake. `in_ready` is high only while the scheduler is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a result is being computed, `in_ready` stays low, and any request offered in that time is not taken. The sender has to hold its request until `in_ready` returns.

The result side has no back-pressure. `out_done` pulses for one cycle when new results appear. The mode and both duty words then hold their values until the next pulse. Buck, bridge-A and gap requests finish in two cycles. Bridge-B and boost need one reciprocal division, and that division runs serially, one quotient bit per cycle.

Top module: `gain_mode_sched`

## Requirements

Gain and duty words are unsigned with 16 fractional bits, so 65536 means 1.0. The gain word has 2 integer bits. Mode codes: 0 = buck, 1 = bridge-A, 2 = bridge-B, 3 = boost. The constants below are K = 65536 − 2163 = 63373, GLO = floor(57344·65536/K) = 59301 and GHI = floor(58982·65536/K) = 60995.

- R1: After reset, `out_mode` is 0, both duty words are 0, `out_done` is low and `in_ready` is high.
- R2: For a gain g ≤ 58982, the mode is 0, the buck duty is g and the boost duty is 0.
- R3: For 58982 < g < GLO, the gain snaps to the nearer reachable point. If g − 58982 ≤ GLO − g, the result is mode 0 with buck duty 58982 and boost duty 0. Otherwise it is mode 1 with buck duty 57344 and boost duty 2163.
- R4: For GLO ≤ g ≤ GHI, the mode is 1 and the boost duty is 2163. The buck duty is floor(g·K/65536), clamped to the range 57344 to 58982.
- R5: For GHI < g < 67764, the mode is 2 and the buck duty is 58982. The boost duty is 65536 − floor(58982·65536/g), but never less than 2163.
- R6: For g ≥ 67764, the mode is 3 and the buck duty is 65536. The boost duty is 65536 − floor(2^32/g), but never less than 2163.
- R7: `in_ready` is low from the edge that takes a request until the result is delivered. A request offered in that window is not taken, and it does not change the result.
- R8: Each accepted request gives exactly one `out_done` pulse, one cycle wide. The mode and duty outputs change only on the edge that raises `out_done`.
- R9: The boost duty is always either 0 or at least 2163. The buck duty is always either at most 58982 or exactly 65536.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Scheduler idle and able to take a request |
| in_gain | input | 18 | Requested gain, 2.16 unsigned |
| out_done | output | 1 | One-cycle pulse when new results are present |
| out_mode | output | 2 | Switching mode code |
| out_buck | output | 17 | Buck duty, 1.16 unsigned |
| out_boost | output | 17 | Boost duty, 1.16 unsigned |

## Verification

The bench aims at the region edges: 58982, both sides of the snap midpoint at 59141/59142, GLO, GHI and the two ends of bridge-B and boost. A classifier with a boundary off by one would put an edge gain in the wrong mode, or would leave a gap or an overlap in the transfer. The boost entry at 67764 and the low-gain end of bridge-A both rely on clamping. A design without that clamp would produce a boost duty of 2155, or a buck duty of 57343, and either value breaks the minimum-pulse window. One test holds a second request on the input during a long division. A scheduler that does not ignore it would return the wrong duties or raise a second done pulse.

// File: rtl/msched_pkg.sv
package msched_pkg;
  typedef enum logic [1:0] {
    MODE_BUCK  = 2'd0,
    MODE_BR_A  = 2'd1,
    MODE_BR_B  = 2'd2,
    MODE_BOOST = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CLASS = 2'd1,
    S_DIV   = 2'd2
  } state_e;
endpackage

// File: rtl/msched_classify.sv
module msched_classify
  import msched_pkg::*;
#(
  parameter int          FRAC       = 16,
  parameter int          GINT       = 2,
  parameter int unsigned BUCK_MAX_Q = 58982,
  parameter int unsigned DBO_MIN_Q  = 2163,
  parameter int unsigned A_LO_DBU_Q = 57344,
  parameter int unsigned BOOST_G_Q  = 67764,
  localparam int GAIN_W = FRAC + GINT,
  localparam int DUTY_W = FRAC + 1
) (
  input  logic [GAIN_W-1:0] gain,
  output mode_e             mode,
  output logic [DUTY_W-1:0] dbu,
  output logic [DUTY_W-1:0] dbo,
  output logic              need_div,
  output logic [DUTY_W-1:0] div_num
);
  localparam logic [63:0] ONE64  = 64'd1 << FRAC;
  localparam logic [63:0] KEEP64 = ONE64 - 64'(DBO_MIN_Q);
  localparam logic [GAIN_W-1:0] G_BMAX  = GAIN_W'(BUCK_MAX_Q);
  localparam logic [GAIN_W-1:0] G_A_LO  = GAIN_W'((64'(A_LO_DBU_Q) << FRAC) / KEEP64);
  localparam logic [GAIN_W-1:0] G_A_HI  = GAIN_W'((64'(BUCK_MAX_Q) << FRAC) / KEEP64);
  localparam logic [GAIN_W-1:0] G_BOOST = GAIN_W'(BOOST_G_Q);
  localparam logic [DUTY_W-1:0] D_ONE  = DUTY_W'(ONE64);
  localparam logic [DUTY_W-1:0] D_BMAX = DUTY_W'(BUCK_MAX_Q);
  localparam logic [DUTY_W-1:0] D_MIN  = DUTY_W'(DBO_MIN_Q);
  localparam logic [DUTY_W-1:0] D_ALO  = DUTY_W'(A_LO_DBU_Q);
  localparam logic [DUTY_W-1:0] D_KEEP = DUTY_W'(KEEP64);
  localparam int PROD_W = GAIN_W + DUTY_W;
  localparam logic [PROD_W-1:0] P_LO = PROD_W'(64'(A_LO_DBU_Q) << FRAC);
  localparam logic [PROD_W-1:0] P_HI = PROD_W'((64'(BUCK_MAX_Q) + 64'd1) << FRAC);

  logic [PROD_W-1:0] prod;
  logic [DUTY_W-1:0] a_dbu;
  logic              snap_low;

  // bridge-A buck duty: gain scaled by (1 - minimum boost duty), clamped
  assign prod = PROD_W'(gain) * PROD_W'(D_KEEP);
  always_comb begin
    if (prod < P_LO)       a_dbu = D_ALO;
    else if (prod >= P_HI) a_dbu = D_BMAX;
    else                   a_dbu = prod[FRAC +: DUTY_W];
  end

  // in the gap, ties go to the buck edge
  assign snap_low = (gain - G_BMAX) <= (G_A_LO - gain);

  always_comb begin
    mode     = MODE_BUCK;
    dbu      = DUTY_W'(gain);
    dbo      = '0;
    need_div = 1'b0;
    div_num  = D_ONE;
    if (gain <= G_BMAX) begin
      mode = MODE_BUCK;
    end else if (gain < G_A_LO) begin
      if (snap_low) begin
        mode = MODE_BUCK;
        dbu  = D_BMAX;
      end else begin
        mode = MODE_BR_A;
        dbu  = D_ALO;
        dbo  = D_MIN;
      end
    end else if (gain <= G_A_HI) begin
      mode = MODE_BR_A;
      dbu  = a_dbu;
      dbo  = D_MIN;
    end else if (gain < G_BOOST) begin
      mode     = MODE_BR_B;
      dbu      = D_BMAX;
      need_div = 1'b1;
      div_num  = D_BMAX;
    end else begin
      mode     = MODE_BOOST;
      dbu      = D_ONE;
      need_div = 1'b1;
      div_num  = D_ONE;
    end
  end
endmodule

// File: rtl/msched_div.sv
module msched_div #(
  parameter int N_W = 33,
  parameter int D_W = 18,
  parameter int Q_W = 17,
  localparam int C_W = $clog2(N_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic [Q_W-1:0] q,
  output logic           q_valid
);
  logic [N_W-1:0] n_sh;
  logic [D_W-1:0] rem;
  logic [D_W-1:0] den_q;
  logic [C_W-1:0] cnt;
  logic [D_W:0]   trial;
  logic           take;

  assign trial = {rem, n_sh[N_W-1]};
  assign take  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_sh    <= '0;
      rem     <= '0;
      den_q   <= '0;
      cnt     <= '0;
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= 1'b0;
      if (start) begin
        n_sh  <= num;
        rem   <= '0;
        den_q <= den;
        q     <= '0;
        cnt   <= C_W'(N_W);
      end else if (cnt != '0) begin
        n_sh    <= n_sh << 1;
        rem     <= take ? D_W'(trial - {1'b0, den_q}) : trial[D_W-1:0];
        q       <= {q[Q_W-2:0], take};
        cnt     <= cnt - 1'b1;
        q_valid <= (cnt == C_W'(1));
      end
    end
  end
endmodule

// File: rtl/gain_mode_sched.sv
module gain_mode_sched
  import msched_pkg::*;
#(
  parameter int          FRAC       = 16,
  parameter int          GINT       = 2,
  parameter int unsigned BUCK_MAX_Q = 58982,
  parameter int unsigned DBO_MIN_Q  = 2163,
  parameter int unsigned A_LO_DBU_Q = 57344,
  parameter int unsigned BOOST_G_Q  = 67764,
  localparam int GAIN_W = FRAC + GINT,
  localparam int DUTY_W = FRAC + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [GAIN_W-1:0] in_gain,
  output logic              out_done,
  output logic [1:0]        out_mode,
  output logic [DUTY_W-1:0] out_buck,
  output logic [DUTY_W-1:0] out_boost
);
  localparam int N_W = DUTY_W + FRAC;
  localparam logic [DUTY_W-1:0] D_ONE = DUTY_W'(64'd1 << FRAC);
  localparam logic [DUTY_W-1:0] D_MIN = DUTY_W'(DBO_MIN_Q);

  state_e            st;
  logic [GAIN_W-1:0] gain_q;
  mode_e             c_mode, pend_mode;
  logic [DUTY_W-1:0] c_dbu, c_dbo, c_num, pend_dbu;
  logic              c_div;
  logic              div_start, q_valid;
  logic [DUTY_W-1:0] q, q_dbo;

  msched_classify #(
    .FRAC(FRAC), .GINT(GINT), .BUCK_MAX_Q(BUCK_MAX_Q), .DBO_MIN_Q(DBO_MIN_Q),
    .A_LO_DBU_Q(A_LO_DBU_Q), .BOOST_G_Q(BOOST_G_Q)
  ) u_cls (
    .gain(gain_q), .mode(c_mode), .dbu(c_dbu), .dbo(c_dbo),
    .need_div(c_div), .div_num(c_num)
  );

  assign div_start = (st == S_CLASS) && c_div;

  msched_div #(.N_W(N_W), .D_W(GAIN_W), .Q_W(DUTY_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num({c_num, {FRAC{1'b0}}}), .den(gain_q),
    .q(q), .q_valid(q_valid)
  );

  assign q_dbo    = D_ONE - q;
  assign in_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      gain_q    <= '0;
      pend_mode <= MODE_BUCK;
      pend_dbu  <= '0;
      out_mode  <= 2'(MODE_BUCK);
      out_buck  <= '0;
      out_boost <= '0;
      out_done  <= 1'b0;
    end else begin
      out_done <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          gain_q <= in_gain;
          st     <= S_CLASS;
        end
        S_CLASS: if (c_div) begin
          pend_mode <= c_mode;
          pend_dbu  <= c_dbu;
          st        <= S_DIV;
        end else begin
          out_mode  <= 2'(c_mode);
          out_buck  <= c_dbu;
          out_boost <= c_dbo;
          out_done  <= 1'b1;
          st        <= S_IDLE;
        end
        S_DIV: if (q_valid) begin
          out_mode  <= 2'(pend_mode);
          out_buck  <= pend_dbu;
          out_boost <= (q_dbo < D_MIN) ? D_MIN : q_dbo;
          out_done  <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gain_mode_sched_chk.sv
module gain_mode_sched_chk #(
  parameter int          FRAC       = 16,
  parameter int unsigned BUCK_MAX_Q = 58982,
  parameter int unsigned DBO_MIN_Q  = 2163,
  localparam int DUTY_W = FRAC + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_done,
  input logic [1:0]        out_mode,
  input logic [DUTY_W-1:0] out_buck,
  input logic [DUTY_W-1:0] out_boost
);
  localparam logic [DUTY_W-1:0] D_ONE  = DUTY_W'(64'd1 << FRAC);
  localparam logic [DUTY_W-1:0] D_BMAX = DUTY_W'(BUCK_MAX_Q);
  localparam logic [DUTY_W-1:0] D_MIN  = DUTY_W'(DBO_MIN_Q);

  p_accept_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> ($stable(out_mode) && $stable(out_buck) && $stable(out_boost)));
  p_boost_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_boost == '0) || (out_boost >= D_MIN));
  p_buck_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_buck <= D_BMAX) || (out_buck == D_ONE));
  p_buck_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd0) |-> (out_boost == '0));
  p_boost_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd3) |-> (out_buck == D_ONE));
endmodule

bind gain_mode_sched gain_mode_sched_chk #(
  .FRAC(FRAC), .BUCK_MAX_Q(BUCK_MAX_Q), .DBO_MIN_Q(DBO_MIN_Q)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_done(out_done), .out_mode(out_mode), .out_buck(out_buck), .out_boost(out_boost)
);

// File: tb/tb_gain_mode_sched.sv
`timescale 1ns/1ps
module tb_gain_mode_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_gain = '0;
  logic        out_done;
  logic [1:0]  out_mode;
  logic [16:0] out_buck, out_boost;

  int total = 0;
  int bad = 0;

  localparam longint ONE  = 65536;
  localparam longint BMAX = 58982;
  localparam longint DMIN = 2163;
  localparam longint ALO  = 57344;
  localparam longint GBST = 67764;
  localparam longint KEEP = ONE - DMIN;
  localparam longint GLO  = (ALO * ONE) / KEEP;
  localparam longint GHI  = (BMAX * ONE) / KEEP;

  always #2.5 clk = ~clk;

  gain_mode_sched dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_gain(in_gain), .out_done(out_done), .out_mode(out_mode),
    .out_buck(out_buck), .out_boost(out_boost)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void expect_for(input longint g, output longint m, output longint bu, output longint bo);
    longint a;
    if (g <= BMAX) begin
      m = 0; bu = g; bo = 0;
    end else if (g < GLO) begin
      if ((g - BMAX) <= (GLO - g)) begin m = 0; bu = BMAX; bo = 0; end
      else begin m = 1; bu = ALO; bo = DMIN; end
    end else if (g <= GHI) begin
      a = (g * KEEP) / ONE;
      if (a < ALO) a = ALO;
      if (a > BMAX) a = BMAX;
      m = 1; bu = a; bo = DMIN;
    end else if (g < GBST) begin
      m = 2; bu = BMAX; bo = ONE - (BMAX * ONE) / g;
      if (bo < DMIN) bo = DMIN;
    end else begin
      m = 3; bu = ONE; bo = ONE - (ONE * ONE) / g;
      if (bo < DMIN) bo = DMIN;
    end
  endfunction

  // offer one request, wait for the done pulse, check results
  task automatic run_gain(input string req, input longint g);
    longint em, ebu, ebo;
    int waited = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_gain  = 18'(g);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk(req, "done seen", longint'(out_done), 1);
    expect_for(g, em, ebu, ebo);
    chk(req, $sformatf("mode g=%0d", g), longint'(out_mode), em);
    chk(req, $sformatf("buck g=%0d", g), longint'(out_buck), ebu);
    chk(req, $sformatf("boost g=%0d", g), longint'(out_boost), ebo);
    chk("R9", "boost window", longint'((out_boost == 0) || (out_boost >= DMIN)), 1);
    chk("R9", "buck window", longint'((out_buck <= BMAX) || (out_buck == ONE)), 1);
    @(negedge clk);
    chk("R8", "done width", longint'(out_done), 0);
    chk("R8", "buck held", longint'(out_buck), ebu);
  endtask

  task automatic t_reset();
    chk("R1", "mode", longint'(out_mode), 0);
    chk("R1", "buck", longint'(out_buck), 0);
    chk("R1", "boost", longint'(out_boost), 0);
    chk("R1", "done", longint'(out_done), 0);
    chk("R1", "ready", longint'(in_ready), 1);
  endtask

  task automatic t_buck();
    run_gain("R2", 0);
    run_gain("R2", 32768);
    run_gain("R2", BMAX);
  endtask

  task automatic t_gap();
    run_gain("R3", 59000);
    run_gain("R3", 59141);
    run_gain("R3", 59142);
  endtask

  task automatic t_bridge_a();
    run_gain("R4", GLO);
    run_gain("R4", 60000);
    run_gain("R4", GHI);
  endtask

  task automatic t_bridge_b();
    run_gain("R5", GHI + 1);
    run_gain("R5", 64000);
    run_gain("R5", 65536);
    run_gain("R5", GBST - 1);
  endtask

  task automatic t_boost();
    run_gain("R6", GBST);
    run_gain("R6", 131072);
    run_gain("R6", 262143);
  endtask

  // second request held on the input while a division runs
  task automatic t_busy();
    longint em, ebu, ebo;
    int dones = 0;
    int busy_ready = 0;
    int waited = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_gain  = 18'd64000;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_gain = 18'd1000;
    while (!out_done && waited < 200) begin
      if (in_ready) busy_ready++;
      @(negedge clk);
      waited++;
    end
    in_valid = 1'b0;
    if (out_done) dones++;
    chk("R7", "ready while busy", busy_ready, 0);
    expect_for(64000, em, ebu, ebo);
    chk("R7", "mode after intrusion", longint'(out_mode), em);
    chk("R7", "boost after intrusion", longint'(out_boost), ebo);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (out_done) dones++;
    end
    chk("R8", "single done", dones, 1);
    chk("R8", "buck held", longint'(out_buck), ebu);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buck();
    t_gap();
    t_bridge_a();
    t_bridge_b();
    t_boost();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule